// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Core

This block keeps the time of day and the calendar in eight byte-wide registers. Seconds, minutes, hours, date, month, day-of-week and year are packed BCD. A single-cycle reference enable, nominally pulsing at 32768 Hz, is divided down to a one-second tick. Each tick advances the seconds. Carries then ripple through minutes and hours. At midnight the date, month, year and day-of-week move on, with the correct month lengths and leap years.

Timekeeping stops while the halt flag in the seconds register is set. The hours register has two encodings, selected by its top bit: a 12-hour encoding with an AM/PM flag, and a 24-hour encoding. An interface block loads any register through a one-cycle write port. All eight registers are visible at all times on a flat read bus. Register k occupies bits 8k+7 down to 8k.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the register values are as follows. Seconds = 0x80, which means halted at 00. Minutes = 0x00. Hours = 0x00 (24-hour mode). Date = 0x01. Month = 0x01. Day-of-week = 0x01. Year = 0x00. Address 7 = 0x80.
- R2: A write to address 0..6 loads seconds, minutes, hours, date, month, day-of-week or year respectively, on the next clock edge. Address 7 keeps only data bit 7, and its bits 6..0 always read 0.
- R3: While seconds bit 7 (halt) is 1, no register advances, however many reference pulses arrive. Clearing the bit resumes counting.
- R4: One tick is produced for every REF_HZ reference pulses, counted while running, whether or not the pulses are contiguous. Each tick adds one to seconds in BCD.
- R5: Seconds and minutes roll from 59 to 00. Each rollover carries one into the next register up.
- R6: In 24-hour mode (hours bit 7 = 0), hours count 00..23 in BCD, with bit 5 acting as the twenties digit. The step from 23 to 00 is the midnight rollover.
- R7: In 12-hour mode (hours bit 7 = 1, bit 5 = PM), hours run 12, 01, ..., 11. The step from 11 to 12 inverts bit 5. Only 11 PM to 12 AM is a midnight rollover.
- R8: At each midnight rollover, day-of-week steps by one and wraps from 07 to 01, independently of the date.
- R9: At midnight the date returns to 01 and the month advances, but only from the last day of the month. April, June, September and November have 30 days. February has 28 days, or 29 in a leap year. All other months have 31 days.
- R10: A year is a leap year when its decimal value is divisible by 4. December rolls to January with the year incremented, and year 99 rolls to 00.
- R11: A write takes priority over the tick-driven update of the same register in the same cycle. A write to seconds also restarts the prescaler, so that the next tick comes REF_HZ pulses later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle pulse per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | 8 | Data to load |
| regs_o | output | 64 | All eight registers, register k at bits 8k+7:8k |

## Verification
The functions that can fall in the same cycle are a register write and the tick-driven increment or carry into that same register. The bench provokes them by raising the write strobe on exactly the reference pulse that completes a second. It does this once with seconds at 59 and the write aimed at minutes, and once with the write aimed at seconds. The write must win in both cases. For the seconds case, the bench then counts reference pulses to confirm that the prescaler restarted from zero rather than resuming its old count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NREG = 8;
  localparam int RW   = 8;

  localparam logic [2:0] ADR_SEC  = 3'd0;
  localparam logic [2:0] ADR_MIN  = 3'd1;
  localparam logic [2:0] ADR_HOUR = 3'd2;
  localparam logic [2:0] ADR_DATE = 3'd3;
  localparam logic [2:0] ADR_MON  = 3'd4;
  localparam logic [2:0] ADR_DOW  = 3'd5;
  localparam logic [2:0] ADR_YEAR = 3'd6;
  localparam logic [2:0] ADR_LOCK = 3'd7;

  typedef struct packed {
    logic [7:0] val;
    logic       wrap;
  } step_t;

  // packed BCD plus one, no range limit
  function automatic logic [7:0] bcd_inc(input logic [7:0] x);
    logic [7:0] r;
    if (x[3:0] >= 4'd9) r = {x[7:4] + 4'd1, 4'd0};
    else                r = {x[7:4], x[3:0] + 4'd1};
    return r;
  endfunction

  // count up to top, then return to bottom and flag the wrap
  function automatic step_t bcd_step(input logic [7:0] x,
                                     input logic [7:0] top,
                                     input logic [7:0] bottom);
    step_t s;
    if (x >= top) begin
      s.val  = bottom;
      s.wrap = 1'b1;
    end else begin
      s.val  = bcd_inc(x);
      s.wrap = 1'b0;
    end
    return s;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] x);
    return 7'(x[7:4]) * 7'd10 + 7'(x[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] year_bcd);
    logic [6:0] b;
    b = bcd_to_bin(year_bcd);
    return (b[1:0] == 2'b00);
  endfunction

  // last valid date of a month, in BCD
  function automatic logic [7:0] month_days(input logic [7:0] mon,
                                            input logic [7:0] year_bcd);
    logic [7:0] d;
    case (mon)
      8'h02:                      d = is_leap(year_bcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

  // hour step; wrap marks the midnight rollover
  function automatic step_t hour_step(input logic [7:0] h);
    step_t s;
    logic [7:0] t;
    s.wrap = 1'b0;
    if (h[7]) begin
      if (h[4:0] == 5'h11) begin
        s.val  = {1'b1, 1'b0, ~h[5], 5'h12};
        s.wrap = h[5];
      end else if (h[4:0] >= 5'h12) begin
        s.val = {1'b1, 1'b0, h[5], 5'h01};
      end else begin
        t     = bcd_inc({3'b000, h[4:0]});
        s.val = {1'b1, 1'b0, h[5], t[4:0]};
      end
    end else begin
      if (h[5:0] >= 6'h23) begin
        s.val  = 8'h00;
        s.wrap = 1'b1;
      end else begin
        t     = bcd_inc({2'b00, h[5:0]});
        s.val = {2'b00, t[5:0]};
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int REF_HZ = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en_i,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);

  localparam int CW = (REF_HZ > 1) ? $clog2(REF_HZ) : 1;
  localparam logic [CW-1:0] LIM = CW'(REF_HZ - 1);

  logic [CW-1:0] cnt_q;
  logic          at_lim;

  assign at_lim = (cnt_q == LIM);
  assign tick_o = ref_en_i & run_i & ~clr_i & at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (ref_en_i && run_i) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end

  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));

  // R11
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  generate
    if (REF_HZ > 1) begin : g_spacing
      // R4
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_carry_o
);

  logic [7:0] sec_q, min_q, hour_q;
  step_t      s_nx, m_nx, h_nx;
  logic       min_adv, hour_adv;
  logic       wr_sec, wr_min, wr_hour;

  assign wr_sec  = wr_en_i && (wr_addr_i == ADR_SEC);
  assign wr_min  = wr_en_i && (wr_addr_i == ADR_MIN);
  assign wr_hour = wr_en_i && (wr_addr_i == ADR_HOUR);

  always_comb begin
    s_nx = bcd_step({1'b0, sec_q[6:0]}, 8'h59, 8'h00);
    m_nx = bcd_step(min_q, 8'h59, 8'h00);
    h_nx = hour_step(hour_q);
  end

  assign min_adv     = tick_i & s_nx.wrap;
  assign hour_adv    = min_adv & m_nx.wrap;
  assign day_carry_o = hour_adv & h_nx.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h80;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_sec)        sec_q  <= wr_data_i;
      else if (tick_i)   sec_q  <= s_nx.val;
      if (wr_min)        min_q  <= wr_data_i;
      else if (min_adv)  min_q  <= m_nx.val;
      if (wr_hour)       hour_q <= wr_data_i;
      else if (hour_adv) hour_q <= h_nx.val;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;

  // R5
  min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_sec && !wr_min && sec_q[6:0] == 7'h59 && min_q < 8'h59)
      |=> (min_q != $past(min_q)) && (sec_q == 8'h00));

  // R6
  hour24_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_adv && !wr_hour && hour_q == 8'h23) |=> (hour_q == 8'h00));

  // R7
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_adv && !wr_hour && hour_q[7] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5])) && (hour_q[4:0] == 5'h12));

  // R11
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_min |=> (min_q == $past(wr_data_i)));

  // R3
  halted_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && !wr_sec) |=> $stable(sec_q));

endmodule

// File: rtl/rtc_date_regs.sv
module rtc_date_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] dow_o,
  output logic [7:0] year_o,
  output logic [7:0] lock_o
);

  logic [7:0] date_q, mon_q, dow_q, year_q;
  logic       lock_q;
  logic [7:0] last_day;
  step_t      d_nx, mo_nx, w_nx, y_nx;
  logic       mon_adv, year_adv;
  logic       wr_date, wr_mon, wr_dow, wr_year, wr_lock;

  assign wr_date = wr_en_i && (wr_addr_i == ADR_DATE);
  assign wr_mon  = wr_en_i && (wr_addr_i == ADR_MON);
  assign wr_dow  = wr_en_i && (wr_addr_i == ADR_DOW);
  assign wr_year = wr_en_i && (wr_addr_i == ADR_YEAR);
  assign wr_lock = wr_en_i && (wr_addr_i == ADR_LOCK);

  always_comb begin
    last_day = month_days(mon_q, year_q);
    d_nx     = bcd_step(date_q, last_day, 8'h01);
    mo_nx    = bcd_step(mon_q, 8'h12, 8'h01);
    w_nx     = bcd_step(dow_q, 8'h07, 8'h01);
    y_nx     = bcd_step(year_q, 8'h99, 8'h00);
  end

  assign mon_adv  = day_carry_i & d_nx.wrap;
  assign year_adv = mon_adv & mo_nx.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      year_q <= 8'h00;
      lock_q <= 1'b1;
    end else begin
      if (wr_date)          date_q <= wr_data_i;
      else if (day_carry_i) date_q <= d_nx.val;
      if (wr_mon)           mon_q  <= wr_data_i;
      else if (mon_adv)     mon_q  <= mo_nx.val;
      if (wr_dow)           dow_q  <= wr_data_i;
      else if (day_carry_i) dow_q  <= w_nx.val;
      if (wr_year)          year_q <= wr_data_i;
      else if (year_adv)    year_q <= y_nx.val;
      if (wr_lock)          lock_q <= wr_data_i[7];
    end
  end

  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign dow_o  = dow_q;
  assign year_o = year_q;
  assign lock_o = {lock_q, 7'b0};

  // R8
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_i && !wr_dow && dow_q == 8'h07) |=> (dow_q == 8'h01));

  // R9
  feb_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_i && !wr_date && !wr_mon && mon_q == 8'h02 && date_q == 8'h28
     && !is_leap(year_q)) |=> (date_q == 8'h01) && (mon_q == 8'h03));

  // R10
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (year_adv && !wr_year && year_q == 8'h99) |=> (year_q == 8'h00));

  // R9
  date_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_carry_i && !wr_date) |=> $stable(date_q));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int REF_HZ = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_en,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [63:0] regs_o
);

  logic [7:0] sec_r, min_r, hour_r, date_r, mon_r, dow_r, year_r, lock_r;
  logic       sec_tick, day_carry, run, pres_clr;

  assign run      = ~sec_r[7];
  assign pres_clr = wr_en && (wr_addr == ADR_SEC);

  rtc_prescaler #(.REF_HZ(REF_HZ)) u_pres (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en_i (ref_en),
    .run_i    (run),
    .clr_i    (pres_clr),
    .tick_o   (sec_tick)
  );

  rtc_time_regs u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (sec_tick),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .sec_o       (sec_r),
    .min_o       (min_r),
    .hour_o      (hour_r),
    .day_carry_o (day_carry)
  );

  rtc_date_regs u_date (
    .clk         (clk),
    .rst_n       (rst_n),
    .day_carry_i (day_carry),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .date_o      (date_r),
    .mon_o       (mon_r),
    .dow_o       (dow_r),
    .year_o      (year_r),
    .lock_o      (lock_r)
  );

  assign regs_o = {lock_r, year_r, dow_r, mon_r, date_r, hour_r, min_r, sec_r};

  // R6
  carry_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> sec_tick);

  // R3
  no_tick_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sec_tick);

endmodule

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;

  localparam int HZ = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [63:0] regs_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_core #(.REF_HZ(HZ)) i_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .regs_o(regs_o)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input int a, input logic [7:0] exp);
    logic [7:0] act;
    act = regs_o[a*8 +: 8];
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s reg%0d actual=%h expected=%h", req, a, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_en = 1'b1;
      @(negedge clk); ref_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  // load a full time and date, seconds last (starts the clock, clears prescaler)
  task automatic load(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                      input logic [7:0] d, input logic [7:0] mo, input logic [7:0] w,
                      input logic [7:0] y);
    wreg(1, mi); wreg(2, h); wreg(3, d); wreg(4, mo); wreg(5, w); wreg(6, y);
    wreg(0, s);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk("R1", 0, 8'h80); chk("R1", 1, 8'h00); chk("R1", 2, 8'h00); chk("R1", 3, 8'h01);
    chk("R1", 4, 8'h01); chk("R1", 5, 8'h01); chk("R1", 6, 8'h00); chk("R1", 7, 8'h80);

    // R2 lock register keeps bit 7 only; address map
    wreg(7, 8'h7F); chk("R2", 7, 8'h00);
    wreg(7, 8'hFF); chk("R2", 7, 8'h80);
    for (int a = 1; a < 7; a++) begin
      wreg(a, bcd(a + 3)); chk("R2", a, bcd(a + 3));
    end

    // R3 halted: pulses have no effect
    wreg(0, 8'h85);
    pulses(3 * HZ, 0);
    chk("R3", 0, 8'h85); chk("R3", 1, bcd(4));
    wreg(0, 8'h05);
    pulses(HZ, 0);
    chk("R3", 0, 8'h06);

    // R4 sparse pulses, one tick per HZ pulses
    wreg(0, 8'h20);
    pulses(HZ - 1, 2); chk("R4", 0, 8'h20);
    pulses(1, 3);      chk("R4", 0, 8'h21);
    pulses(2 * HZ, 1); chk("R4", 0, 8'h23);

    // R4/R5 seconds sweep, carry into minutes
    for (int s = 0; s < 60; s++) begin
      wreg(1, 8'h30);
      wreg(0, bcd(s));
      pulses(HZ, 0);
      chk("R4", 0, bcd((s + 1) % 60));
      chk("R5", 1, (s == 59) ? 8'h31 : 8'h30);
    end
    // R5 minutes rollover into hours
    load(8'h59, 8'h59, 8'h05, 8'h10, 8'h05, 8'h03, 8'h20);
    pulses(HZ, 0);
    chk("R5", 1, 8'h00); chk("R5", 2, 8'h06);

    // R6 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      load(8'h59, 8'h59, bcd(h), 8'h10, 8'h05, 8'h03, 8'h20);
      pulses(HZ, 0);
      chk("R6", 2, bcd((h + 1) % 24));
      chk("R6", 3, (h == 23) ? 8'h11 : 8'h10);
    end

    // R7 12-hour sweep
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh, npm;
        bit mid;
        nh  = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        mid = (h == 11) && (pm == 1);
        load(8'h59, 8'h59, 8'h80 | (pm ? 8'h20 : 8'h00) | bcd(h), 8'h10, 8'h05, 8'h03, 8'h20);
        pulses(HZ, 0);
        chk("R7", 2, 8'h80 | (npm ? 8'h20 : 8'h00) | bcd(nh));
        chk("R7", 3, mid ? 8'h11 : 8'h10);
      end
    end

    // R8 day-of-week sweep
    for (int w = 1; w <= 7; w++) begin
      load(8'h59, 8'h59, 8'h23, 8'h10, 8'h05, bcd(w), 8'h20);
      pulses(HZ, 0);
      chk("R8", 5, bcd((w % 7) + 1));
    end

    // R9/R10 month lengths across several years
    for (int yi = 0; yi < 5; yi++) begin
      int y;
      y = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 4 : (yi == 3) ? 30 : 99;
      for (int m = 1; m <= 12; m++) begin
        int dm;
        dm = mdays(m, y);
        load(8'h59, 8'h59, 8'h23, bcd(dm - 1), bcd(m), 8'h02, bcd(y));
        pulses(HZ, 0);
        chk("R9", 3, bcd(dm)); chk("R9", 4, bcd(m));
        load(8'h59, 8'h59, 8'h23, bcd(dm), bcd(m), 8'h02, bcd(y));
        pulses(HZ, 0);
        chk("R9", 3, 8'h01);
        chk("R9", 4, bcd((m % 12) + 1));
        chk("R10", 6, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
      end
    end

    // R11 write to minutes on the tick that carries into minutes
    load(8'h59, 8'h10, 8'h05, 8'h10, 8'h05, 8'h03, 8'h20);
    pulses(HZ - 1, 0);
    @(negedge clk);
    ref_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h42;
    @(negedge clk);
    ref_en = 1'b0; wr_en = 1'b0;
    chk("R11", 0, 8'h00); chk("R11", 1, 8'h42);

    // R11 write to seconds on the tick cycle, prescaler restarts
    wreg(0, 8'h30);
    pulses(HZ - 1, 0);
    @(negedge clk);
    ref_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h10;
    @(negedge clk);
    ref_en = 1'b0; wr_en = 1'b0;
    chk("R11", 0, 8'h10);
    pulses(HZ - 1, 0); chk("R11", 0, 8'h10);
    pulses(1, 0);      chk("R11", 0, 8'h11);

    report();
  end

endmodule